// File: doc/BRIEF.md
# Data Space with Pointer Redirection

This block is the 64-byte data space of a small 8-bit controller core. A 6-bit address selects either one of a handful of special registers, a reserved hole, or one of 32 bytes of general-purpose RAM. Reads are combinational from the presented address. Writes and single-bit updates take effect at the next rising clock edge.

Address 00H holds no storage. Any access to it is steered through a 6-bit pointer register. When that pointer itself holds 00H, the access becomes a null access. A bit-set or bit-clear strobe, together with a 3-bit bit index, performs a read-modify-write in one clock on whatever location the effective address selects. The core sees the accumulator, status and the three port registers on dedicated outputs. The program-counter low byte and the table high byte are kept outside the block and reach it through hooks: a value input for reading, and a load strobe for writing the PC byte.

Top module: `dmem_space`

## Requirements
- R1: Addresses 20H..3FH are 32 bytes of RAM. A write is visible on `rd_data` from the clock edge that accepts it onward, and reads are combinational.
- R2: Special register addresses: pointer 01H, accumulator 05H, PC low 06H, table pointer 07H, table high 08H, status 0AH, ports 12H/14H/16H (port A/B/C). The accumulator, status and port registers read back what was written and appear on `acc_q`, `status_q` and `port_a_q`/`port_b_q`/`port_c_q`.
- R3: Every other address below 20H is reserved. It reads 00H, and writes and bit strobes aimed at it change nothing.
- R4: An access to 00H reads, writes or bit-updates the location whose address is held in the pointer.
- R5: When the pointer holds 00H, a read of 00H returns 00H, and a write or bit strobe on 00H changes nothing.
- R6: The pointer stores only bits 5:0 of written data. Bits 7:6 always read as 1.
- R7: `bit_set` sets and `bit_clr` clears bit `bit_idx` (0 = LSB) of the effective location in one clock. All other bits keep their value. This works both directly and through the pointer.
- R8: With `bit_set` and `bit_clr` both high, the bit is cleared.
- R9: While `wr_en` is high, the bit strobes are ignored and `wr_data` is stored.
- R10: Address 06H reads `pcl_in`. A write or bit update there raises `pcl_ld` combinationally, in the same cycle, with the new byte on `pcl_ld_val`. Address 08H reads `tblh_in` and ignores writes.
- R11: While `rst_n` is low, the pointer, accumulator, status, table pointer and ports clear to 0 (the pointer then reads C0H). RAM is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Direct address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Byte write strobe |
| bit_set | input | 1 | Set one bit of the addressed byte |
| bit_clr | input | 1 | Clear one bit of the addressed byte |
| bit_idx | input | 3 | Bit selected by the bit strobes |
| pcl_in | input | 8 | Current PC low byte from outside |
| tblh_in | input | 8 | Table high byte from outside |
| rd_data | output | 8 | Read data of the effective location |
| pcl_ld | output | 1 | PC low byte load request |
| pcl_ld_val | output | 8 | Value to load into the PC low byte |
| acc_q | output | 8 | Accumulator |
| status_q | output | 8 | Status register |
| port_a_q | output | 8 | Port A register |
| port_b_q | output | 8 | Port B register |
| port_c_q | output | 8 | Port C register |

## Verification
The hardest situation to reach is the null access: the pointer has to hold 00H, and a write or bit strobe then has to be aimed at 00H. Nothing should change as a result. The stimulus first loads the accumulator and a RAM byte with known values. It then writes 00H to the pointer and issues the write and the strobes on 00H. Finally it reads back the accumulator, that RAM byte and the pointer through the ordinary ports. Bit updates through the pointer are reached the same way: the pointer is aimed at a RAM byte, and the strobes are then applied at 00H.

// File: rtl/dmem_pkg.sv
// Package: shared widths, address map and types for the data space.
// Assumes a 6-bit address and 8-bit data. The map constants are fixed by
// the core's instruction decode.
package dmem_pkg;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int BW = $clog2(DW);

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    localparam addr_t A_IND   = 6'h00;
    localparam addr_t A_PTR   = 6'h01;
    localparam addr_t A_ACC   = 6'h05;
    localparam addr_t A_PCL   = 6'h06;
    localparam addr_t A_TBP   = 6'h07;
    localparam addr_t A_TBH   = 6'h08;
    localparam addr_t A_STS   = 6'h0A;
    localparam addr_t A_PORT0 = 6'h12;

    localparam int PORT_CNT    = 3;
    localparam int PORT_STRIDE = 2;
    localparam int GPR_BASE    = 32;
    localparam int GPR_DEPTH   = 32;
endpackage

// File: rtl/dmem_redirect.sv
// Module: effective-address selection.
// Replaces address 00H with the pointer value and flags a null access when
// the result is 00H again. Purely combinational.
module dmem_redirect
    import dmem_pkg::*;
(
    input  addr_t addr,
    input  addr_t ptr,
    output addr_t eff,
    output logic  null_acc
);
    // Substitute the pointer for the indirect location; detect self-reference.
    always_comb begin
        eff      = (addr == A_IND) ? ptr : addr;
        null_acc = (eff == A_IND);
    end
endmodule

// File: rtl/dmem_gpr.sv
// Module: general-purpose RAM window.
// Holds DEPTH bytes starting at BASE. Reads are combinational and writes
// are taken at the clock edge. Contents are not reset. Assumes DEPTH is a
// power of two and that the window ends at or below the top of the address
// space.
module dmem_gpr
    import dmem_pkg::*;
#(
    parameter int BASE  = GPR_BASE,
    parameter int DEPTH = GPR_DEPTH
) (
    input  logic  clk,
    input  addr_t eff,
    input  logic  we,
    input  byte_t wdata,
    output byte_t rdata,
    output logic  hit
);
    localparam int IW = $clog2(DEPTH);

    byte_t           mem [DEPTH];
    logic [IW-1:0]   idx;

    // Window hit test and row index.
    always_comb begin
        hit   = (int'(eff) >= BASE) && (int'(eff) < BASE + DEPTH);
        idx   = IW'(eff - AW'(BASE));
        rdata = mem[idx];
    end

    // Store a byte into the selected row.
    always_ff @(posedge clk) begin
        if (we && hit) mem[idx] <= wdata;
    end
endmodule

// File: rtl/dmem_sfr.sv
// Module: special register file.
// Holds the pointer, accumulator, table pointer, status and port registers,
// and forwards reads of the external PC-low and table-high hooks. Returns 0
// for any address it does not own. Writes to the PC-low address become a
// load strobe. Synchronous active-low reset.
module dmem_sfr
    import dmem_pkg::*;
#(
    parameter int    NPORT = PORT_CNT,
    parameter int    PSTEP = PORT_STRIDE,
    parameter addr_t PBASE = A_PORT0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  addr_t                 eff,
    input  logic                  we,
    input  byte_t                 wdata,
    input  byte_t                 pcl_in,
    input  byte_t                 tblh_in,
    output byte_t                 rdata,
    output addr_t                 ptr_q,
    output byte_t                 acc_q,
    output byte_t                 status_q,
    output byte_t                 tblp_q,
    output logic [NPORT-1:0][DW-1:0] port_q,
    output logic                  pcl_ld,
    output byte_t                 pcl_ld_val
);
    localparam int FILL = DW - AW;

    // Core registers: pointer keeps the low AW bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            acc_q    <= '0;
            status_q <= '0;
            tblp_q   <= '0;
        end else if (we) begin
            case (eff)
                A_PTR:   ptr_q    <= wdata[AW-1:0];
                A_ACC:   acc_q    <= wdata;
                A_STS:   status_q <= wdata;
                A_TBP:   tblp_q   <= wdata;
                default: ;
            endcase
        end
    end

    // One register per port, spaced PSTEP apart from PBASE.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam addr_t PADDR = PBASE + addr_t'(g * PSTEP);
        // Port g register update.
        always_ff @(posedge clk) begin
            if (!rst_n)                  port_q[g] <= '0;
            else if (we && eff == PADDR) port_q[g] <= wdata;
        end
    end

    // Read multiplexer; unowned addresses yield zero.
    always_comb begin
        rdata = '0;
        case (eff)
            A_PTR:   rdata = {{FILL{1'b1}}, ptr_q};
            A_ACC:   rdata = acc_q;
            A_PCL:   rdata = pcl_in;
            A_TBP:   rdata = tblp_q;
            A_TBH:   rdata = tblh_in;
            A_STS:   rdata = status_q;
            default: ;
        endcase
        for (int p = 0; p < NPORT; p++) begin
            if (eff == PBASE + addr_t'(p * PSTEP)) rdata = port_q[p];
        end
    end

    // PC-low writes leave the block as a load request.
    always_comb begin
        pcl_ld     = we && (eff == A_PCL);
        pcl_ld_val = wdata;
    end
endmodule

// File: rtl/dmem_space.sv
// Module: data space top.
// Resolves the effective address, reads the selected location, merges a
// byte write or a single-bit update into it and commits the result in one
// clock. The byte write outranks the bit strobes, and clear outranks set.
// A null access (pointer aimed at 00H) reads 0 and commits nothing.
module dmem_space
    import dmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  addr,
    input  logic [7:0]  wr_data,
    input  logic        wr_en,
    input  logic        bit_set,
    input  logic        bit_clr,
    input  logic [2:0]  bit_idx,
    input  logic [7:0]  pcl_in,
    input  logic [7:0]  tblh_in,
    output logic [7:0]  rd_data,
    output logic        pcl_ld,
    output logic [7:0]  pcl_ld_val,
    output logic [7:0]  acc_q,
    output logic [7:0]  status_q,
    output logic [7:0]  port_a_q,
    output logic [7:0]  port_b_q,
    output logic [7:0]  port_c_q
);
    addr_t eff;
    logic  null_acc;
    addr_t ptr_q;
    byte_t sfr_rd, gpr_rd, tblp_q, mask, new_val;
    logic  gpr_hit, commit;
    logic [PORT_CNT-1:0][DW-1:0] port_q;

    dmem_redirect u_redir (
        .addr     (addr),
        .ptr      (ptr_q),
        .eff      (eff),
        .null_acc (null_acc)
    );

    // Read path and merge of the new byte value.
    always_comb begin
        rd_data = null_acc ? '0 : (gpr_hit ? gpr_rd : sfr_rd);
        mask    = byte_t'(1) << bit_idx;
        if (wr_en)        new_val = wr_data;
        else if (bit_clr) new_val = rd_data & ~mask;
        else              new_val = rd_data | mask;
        commit  = (wr_en || bit_set || bit_clr) && !null_acc;
    end

    dmem_sfr u_sfr (
        .clk        (clk),
        .rst_n      (rst_n),
        .eff        (eff),
        .we         (commit),
        .wdata      (new_val),
        .pcl_in     (pcl_in),
        .tblh_in    (tblh_in),
        .rdata      (sfr_rd),
        .ptr_q      (ptr_q),
        .acc_q      (acc_q),
        .status_q   (status_q),
        .tblp_q     (tblp_q),
        .port_q     (port_q),
        .pcl_ld     (pcl_ld),
        .pcl_ld_val (pcl_ld_val)
    );

    dmem_gpr u_gpr (
        .clk   (clk),
        .eff   (eff),
        .we    (commit),
        .wdata (new_val),
        .rdata (gpr_rd),
        .hit   (gpr_hit)
    );

    // Export the port registers by name.
    always_comb begin
        port_a_q = port_q[0];
        port_b_q = port_q[1];
        port_c_q = port_q[2];
    end
endmodule

// File: rtl/dmem_space_chk.sv
// Module: property checker for dmem_space, attached with bind.
// Uses only the ports of the top module. The reserved-address test is
// written out independently from the address map in the requirements.
module dmem_space_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] addr,
    input logic [7:0] wr_data,
    input logic       wr_en,
    input logic       bit_set,
    input logic       bit_clr,
    input logic [2:0] bit_idx,
    input logic [7:0] tblh_in,
    input logic [7:0] rd_data,
    input logic [7:0] acc_q,
    input logic [7:0] status_q,
    input logic [7:0] port_a_q,
    input logic [7:0] port_b_q,
    input logic [7:0] port_c_q
);
    function automatic logic rsv(input logic [5:0] a);
        return (a < 6'h20) && !(a inside {6'h00, 6'h01, 6'h05, 6'h06,
                6'h07, 6'h08, 6'h0A, 6'h12, 6'h14, 6'h16});
    endfunction

    assert_rsv_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsv(addr) |-> rd_data == 8'h00);

    assert_rsv_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv(addr) && (wr_en || bit_set || bit_clr)) |=>
        ($stable(acc_q) && $stable(status_q) && $stable(port_a_q)
         && $stable(port_b_q) && $stable(port_c_q)));

    assert_ptr_top_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 6'h01 |-> rd_data[7:6] == 2'b11);

    assert_acc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 6'h05) |=> acc_q == $past(wr_data));

    assert_bit_set_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bit_set && !bit_clr && addr == 6'h05) |=>
        acc_q == ($past(acc_q) | (8'h01 << $past(bit_idx))));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bit_set && bit_clr && addr == 6'h05) |=>
        acc_q == ($past(acc_q) & ~(8'h01 << $past(bit_idx))));

    assert_write_beats_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bit_set || bit_clr) && addr == 6'h0A) |=>
        status_q == $past(wr_data));

    assert_tblh_hook_R10: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 6'h08 |-> rd_data == tblh_in);
endmodule

bind dmem_space dmem_space_chk u_chk (.*);

// File: tb/sim_dmem_space.sv
// Directed bench for dmem_space: one task per scenario, each checking itself.
module sim_dmem_space;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       bit_set = 1'b0;
    logic       bit_clr = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] pcl_in = 8'h00;
    logic [7:0] tblh_in = 8'h00;
    logic [7:0] rd_data, pcl_ld_val, acc_q, status_q, port_a_q, port_b_q, port_c_q;
    logic       pcl_ld;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    dmem_space u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bitop(input logic [5:0] a, input logic [2:0] i, input logic s, input logic c);
        @(negedge clk);
        addr = a; bit_idx = i; bit_set = s; bit_clr = c;
        @(negedge clk);
        bit_set = 1'b0; bit_clr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R11 port_a", port_a_q, 8'h00);
        chk("R11 port_b", port_b_q, 8'h00);
        chk("R11 port_c", port_c_q, 8'h00);
        chk("R11 acc", acc_q, 8'h00);
        chk("R11 status", status_q, 8'h00);
        rd(6'h01, v); chk("R11 pointer reads C0", v, 8'hC0);
    endtask

    task automatic t_ram;
        logic [7:0] v;
        wr(6'h20, 8'h11); wr(6'h2A, 8'hA5); wr(6'h3F, 8'h7E);
        rd(6'h20, v); chk("R1 ram 20", v, 8'h11);
        rd(6'h2A, v); chk("R1 ram 2A", v, 8'hA5);
        rd(6'h3F, v); chk("R1 ram 3F", v, 8'h7E);
    endtask

    task automatic t_sfr;
        logic [7:0] v;
        wr(6'h05, 8'h5A); wr(6'h0A, 8'h3C); wr(6'h07, 8'h81);
        wr(6'h12, 8'h01); wr(6'h14, 8'h02); wr(6'h16, 8'h04);
        chk("R2 acc_q", acc_q, 8'h5A);
        chk("R2 status_q", status_q, 8'h3C);
        chk("R2 port_a_q", port_a_q, 8'h01);
        chk("R2 port_b_q", port_b_q, 8'h02);
        chk("R2 port_c_q", port_c_q, 8'h04);
        rd(6'h07, v); chk("R2 table pointer", v, 8'h81);
        rd(6'h14, v); chk("R2 port_b read", v, 8'h02);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        wr(6'h13, 8'hFF); wr(6'h02, 8'hFF);
        bitop(6'h15, 3'd3, 1'b1, 1'b0);
        rd(6'h13, v); chk("R3 13 reads 0", v, 8'h00);
        rd(6'h15, v); chk("R3 15 reads 0", v, 8'h00);
        rd(6'h1F, v); chk("R3 1F reads 0", v, 8'h00);
        chk("R3 port_a kept", port_a_q, 8'h01);
        chk("R3 port_b kept", port_b_q, 8'h02);
        chk("R3 port_c kept", port_c_q, 8'h04);
        chk("R3 acc kept", acc_q, 8'h5A);
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        wr(6'h01, 8'hFF); rd(6'h01, v); chk("R6 ptr FF", v, 8'hFF);
        wr(6'h01, 8'h2A); rd(6'h01, v); chk("R6 ptr 2A", v, 8'hEA);
        bitop(6'h01, 3'd7, 1'b0, 1'b1); rd(6'h01, v); chk("R6 ptr bit7", v, 8'hEA);
        bitop(6'h01, 3'd0, 1'b1, 1'b0); rd(6'h01, v); chk("R6 ptr bit0", v, 8'hEB);
    endtask

    task automatic t_indirect;
        logic [7:0] v;
        wr(6'h01, 8'h25); wr(6'h00, 8'h77);
        rd(6'h25, v); chk("R4 write via ptr", v, 8'h77);
        rd(6'h00, v); chk("R4 read via ptr", v, 8'h77);
        wr(6'h01, 8'h05); wr(6'h00, 8'hC3);
        chk("R4 acc via ptr", acc_q, 8'hC3);
    endtask

    task automatic t_null;
        logic [7:0] v;
        wr(6'h05, 8'h5A); wr(6'h20, 8'h11);
        wr(6'h01, 8'h00);
        rd(6'h00, v); chk("R5 null read", v, 8'h00);
        wr(6'h00, 8'h99);
        bitop(6'h00, 3'd0, 1'b1, 1'b0);
        chk("R5 acc kept", acc_q, 8'h5A);
        rd(6'h20, v); chk("R5 ram kept", v, 8'h11);
        rd(6'h01, v); chk("R5 ptr kept", v, 8'hC0);
        rd(6'h00, v); chk("R5 null read after", v, 8'h00);
    endtask

    task automatic t_bits;
        logic [7:0] v;
        wr(6'h30, 8'h00);
        bitop(6'h30, 3'd7, 1'b1, 1'b0); rd(6'h30, v); chk("R7 set b7", v, 8'h80);
        bitop(6'h30, 3'd0, 1'b1, 1'b0); rd(6'h30, v); chk("R7 set b0", v, 8'h81);
        bitop(6'h30, 3'd7, 1'b0, 1'b1); rd(6'h30, v); chk("R7 clr b7", v, 8'h01);
        wr(6'h01, 8'h30);
        bitop(6'h00, 3'd4, 1'b1, 1'b0); rd(6'h30, v); chk("R7 set via ptr", v, 8'h11);
        bitop(6'h00, 3'd0, 1'b0, 1'b1); rd(6'h30, v); chk("R7 clr via ptr", v, 8'h10);
    endtask

    task automatic t_clear_wins;
        logic [7:0] v;
        wr(6'h31, 8'hFF);
        bitop(6'h31, 3'd2, 1'b1, 1'b1); rd(6'h31, v); chk("R8 clear wins", v, 8'hFB);
        wr(6'h05, 8'h00);
        bitop(6'h05, 3'd1, 1'b1, 1'b1); chk("R8 acc clear wins", acc_q, 8'h00);
    endtask

    task automatic t_write_prio;
        @(negedge clk);
        addr = 6'h0A; wr_data = 8'h40; wr_en = 1'b1; bit_idx = 3'd0; bit_set = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bit_set = 1'b0;
        chk("R9 write beats set", status_q, 8'h40);
    endtask

    task automatic t_hooks;
        logic [7:0] v;
        pcl_in = 8'h80; tblh_in = 8'h3D;
        rd(6'h06, v); chk("R10 pcl read", v, 8'h80);
        rd(6'h08, v); chk("R10 tblh read", v, 8'h3D);
        @(negedge clk);
        chk("R10 pcl_ld idle", {7'd0, pcl_ld}, 8'h00);
        addr = 6'h06; wr_data = 8'h3C; wr_en = 1'b1;
        #1;
        chk("R10 pcl_ld on write", {7'd0, pcl_ld}, 8'h01);
        chk("R10 pcl_ld_val write", pcl_ld_val, 8'h3C);
        @(negedge clk);
        wr_en = 1'b0; bit_idx = 3'd0; bit_set = 1'b1;
        #1;
        chk("R10 pcl_ld_val bit", pcl_ld_val, 8'h81);
        @(negedge clk);
        bit_set = 1'b0;
        wr(6'h08, 8'hFF);
        rd(6'h08, v); chk("R10 tblh not written", v, 8'h3D);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ram();
        t_sfr();
        t_reserved();
        t_pointer();
        t_indirect();
        t_null();
        t_bits();
        t_clear_wins();
        t_write_prio();
        t_hooks();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule